// File: doc/BRIEF.md
# GPIO bank with interrupt control

This block manages one bank of 32 general-purpose pins from a simple 32-bit register bus. Software uses it to make each pin an input or an output and to drive output levels. It can also read back pin levels, which reach the block through a two-flop synchroniser. Direction, output level and interrupt configuration each have an atomic pair of write aliases, one to set bits and one to clear them, so software never needs a read-modify-write sequence.

The eight lowest pins can raise interrupts. Each of these pins has a rise/high enable, a fall/low enable, a debounce enable and a level-mode select, all packed into one control word. In edge mode the enables select the rising edge, the falling edge or both edges. In level mode the same enables select active-high or active-low. Events are held in a pending register until software clears them with a write-one-to-clear. The OR of the pending bits forms a single interrupt line.

Bus reads are combinational from `bus_addr`. A write takes effect at the clock edge on which `bus_sel` and `bus_we` are both high.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, every pin is an input, so register 0x00 reads all ones and `pin_oe` is zero. `pin_out` is zero, the control word at 0x18 reads zero, status at 0x24 reads zero and `irq_out` is low.
- R2: A write to 0x04 makes every pin whose data bit is 1 an output, and a write to 0x08 makes every such pin an input. Zero data bits leave a pin unchanged. Register 0x00 holds 1 for an input pin, and `pin_oe` is its bitwise inverse.
- R3: A write to 0x10 sets the output latch bits that are 1 in the data, and a write to 0x14 clears them. Zero bits are untouched. `pin_out` shows the latch, and a read of 0x10 returns it.
- R4: A read of 0x0C returns the pin levels after the two-flop synchroniser, for all 32 pins.
- R5: The control word is set by writing ones at 0x18 and cleared by writing ones at 0x1C, and a read of either offset returns it. Its fields are: rise/high enable in bits [7:0], fall/low enable in [15:8], debounce in [23:16], and level select in [31:24], where 1 means level mode.
- R6: In edge mode a pending bit is set by a rising edge when the rise enable is set, by a falling edge when the fall enable is set, and by either edge when both are set. Pending bits are read at 0x24, with bit n belonging to pin n.
- R7: In level mode, a pin with its high enable set is pending while it is high, and a pin with its low enable set is pending while it is low. When a clear arrives in a cycle where the level condition still holds, the bit stays pending.
- R8: A pin with both its rise and fall enables at zero never becomes pending, even with the level select set. Pins 8 to 31 never raise interrupts, and status bits [31:8] always read zero.
- R9: Writing a 1 at 0x20 clears the matching pending bit, provided no new event arrives in the same cycle. Zero bits leave pending bits as they are.
- R10: `irq_out` is high exactly when some status bit [7:0] is set.
- R11: When a pin's debounce bit is set, a new synchronised level must persist for 16 consecutive cycles before the detector sees it. A shorter pulse produces no event.
- R12: Writes to 0x00, 0x0C and 0x24 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output level |
| irq_out | output | 1 | Combined interrupt line |

## Verification
Two things can land on the same pending bit in the same cycle: a write-one-to-clear from the bus and a new trigger from the detector. The bench provokes this on a level-mode pin whose level condition is still true when the clear arrives. It then reads the status and requires the bit to still be set. After the pin returns to its inactive level, a second clear must empty the bit. Edge, mask, debounce and register-alias behaviour come from directed cases, and a seeded random mix of bus writes is compared against bench-side models of the direction and output registers.

// File: rtl/gpio_bank_pkg.sv
// Shared offsets and write-strobe type for the GPIO bank.
// Assumes byte offsets on an 8-bit address and 32-bit registers.
package gpio_bank_pkg;
    localparam logic [7:0] OFS_DIR      = 8'h00;
    localparam logic [7:0] OFS_MK_OUT   = 8'h04;
    localparam logic [7:0] OFS_MK_IN    = 8'h08;
    localparam logic [7:0] OFS_PINS     = 8'h0C;
    localparam logic [7:0] OFS_OUT_SET  = 8'h10;
    localparam logic [7:0] OFS_OUT_CLR  = 8'h14;
    localparam logic [7:0] OFS_ICTL_SET = 8'h18;
    localparam logic [7:0] OFS_ICTL_CLR = 8'h1C;
    localparam logic [7:0] OFS_PEND_CLR = 8'h20;
    localparam logic [7:0] OFS_PEND     = 8'h24;

    typedef struct packed {
        logic mk_out;
        logic mk_in;
        logic out_set;
        logic out_clr;
        logic ictl_set;
        logic ictl_clr;
        logic pend_clr;
    } wr_strobe_t;
endpackage

// File: rtl/gpio_regs.sv
// Configuration registers: direction, output latch and interrupt control.
// Each one is updated only through its set and clear write strobes.
// Assumes the strobes are one-hot per cycle (decoded from one address).
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IRQ_PINS = 8,
    localparam int unsigned CTL_W   = 4 * IRQ_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] out_q,
    output logic [CTL_W-1:0]  ictl_q
);

    // Direction: 1 = input; reset leaves every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n)         dir_q <= '1;
        else if (wr.mk_out) dir_q <= dir_q & ~wdata;
        else if (wr.mk_in)  dir_q <= dir_q | wdata;
    end

    // Output latch with set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)          out_q <= '0;
        else if (wr.out_set) out_q <= out_q | wdata;
        else if (wr.out_clr) out_q <= out_q & ~wdata;
    end

    // Packed interrupt-control word with set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)           ictl_q <= '0;
        else if (wr.ictl_set) ictl_q <= ictl_q | wdata[CTL_W-1:0];
        else if (wr.ictl_clr) ictl_q <= ictl_q & ~wdata[CTL_W-1:0];
    end

    AST_MK_OUT_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        wr.mk_out |=> ((dir_q & $past(wdata)) == '0)); // R2
    AST_MK_IN_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        wr.mk_in |=> ((dir_q & $past(wdata)) == $past(wdata))); // R2
    AST_OUT_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        wr.out_set |=> ((out_q & $past(wdata)) == $past(wdata))); // R3
    AST_OUT_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        wr.out_clr |=> ((out_q & $past(wdata)) == '0)); // R3
    AST_DIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr.mk_out || wr.mk_in) |=> $stable(dir_q)); // R12

endmodule

// File: rtl/gpio_in_filter.sv
// Per-pin input path: a synchroniser chain, then an optional debounce
// stage. With debounce enabled, a new level must persist DB_CYCLES
// cycles before the filtered output follows it. With it disabled, the
// output follows the synchronised level one cycle later.
// Assumes SYNC_STAGES >= 2 and DB_CYCLES >= 1.
module gpio_in_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DB_CYCLES   = 16,
    localparam int unsigned CNT_W      = $clog2(DB_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic db_en_i,
    output logic sync_o,
    output logic filt_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DB_CYCLES - 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [CNT_W-1:0]       cnt;

    // Synchroniser shift chain for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], pin_i};
    end

    assign sync_o = chain[SYNC_STAGES-1];

    // Debounce: accept a changed level only after it has held LIMIT+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o <= 1'b0;
            cnt    <= '0;
        end else if (!db_en_i) begin
            filt_o <= sync_o;
            cnt    <= '0;
        end else if (sync_o == filt_o) begin
            cnt    <= '0;
        end else if (cnt == LIMIT) begin
            filt_o <= sync_o;
            cnt    <= '0;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    AST_DB_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(db_en_i) && (filt_o != $past(filt_o))) |-> ($past(cnt) == LIMIT)); // R11

endmodule

// File: rtl/gpio_irq_detect.sv
// Edge and level trigger detection with a sticky pending register.
// A new trigger takes priority over a clear in the same cycle.
// Assumes filtered inputs are already synchronous to clk.
module gpio_irq_detect #(
    parameter int unsigned IRQ_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IRQ_PINS-1:0] lvl_i,
    input  logic [IRQ_PINS-1:0] rise_en,
    input  logic [IRQ_PINS-1:0] fall_en,
    input  logic [IRQ_PINS-1:0] lvl_mode,
    input  logic [IRQ_PINS-1:0] clr_i,
    output logic [IRQ_PINS-1:0] pend_q
);
    logic [IRQ_PINS-1:0] prev_q;
    logic [IRQ_PINS-1:0] edge_hit;
    logic [IRQ_PINS-1:0] level_hit;
    logic [IRQ_PINS-1:0] trig;

    // Previous filtered level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // Per-pin trigger selection between edge and level modes.
    always_comb begin
        edge_hit  = (rise_en & lvl_i & ~prev_q) | (fall_en & ~lvl_i & prev_q);
        level_hit = (rise_en & lvl_i) | (fall_en & ~lvl_i);
        trig      = (lvl_mode & level_hit) | (~lvl_mode & edge_hit);
    end

    // Sticky pending bits; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | trig;
    end

    AST_DROP_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0)); // R9
    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~($past(rise_en) | $past(fall_en))) == '0)); // R8
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lvl_mode & rise_en & lvl_i) & ~pend_q) == '0)); // R7

endmodule

// File: rtl/gpio_bank_irq.sv
// Top of the GPIO bank: bus decode, read mux, per-pin input filters,
// configuration registers and interrupt detection for the low pins.
// Assumes single-cycle bus writes and combinational reads.
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned IRQ_PINS    = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DB_CYCLES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pin_out,
    output logic              irq_out
);
    localparam int unsigned CTL_W = 4 * IRQ_PINS;

    wr_strobe_t          wr;
    logic [DATA_W-1:0]   dir_q;
    logic [DATA_W-1:0]   out_q;
    logic [CTL_W-1:0]    ictl_q;
    logic [DATA_W-1:0]   sync_v;
    logic [DATA_W-1:0]   filt_v;
    logic [IRQ_PINS-1:0] pend_q;
    logic [IRQ_PINS-1:0] clr_v;
    logic                wr_act;

    // Write decode: one strobe per aliased offset.
    always_comb begin
        wr_act      = bus_sel && bus_we;
        wr.mk_out   = wr_act && (bus_addr == OFS_MK_OUT);
        wr.mk_in    = wr_act && (bus_addr == OFS_MK_IN);
        wr.out_set  = wr_act && (bus_addr == OFS_OUT_SET);
        wr.out_clr  = wr_act && (bus_addr == OFS_OUT_CLR);
        wr.ictl_set = wr_act && (bus_addr == OFS_ICTL_SET);
        wr.ictl_clr = wr_act && (bus_addr == OFS_ICTL_CLR);
        wr.pend_clr = wr_act && (bus_addr == OFS_PEND_CLR);
        clr_v       = bus_wdata[IRQ_PINS-1:0] & {IRQ_PINS{wr.pend_clr}};
    end

    gpio_regs #(.DATA_W(DATA_W), .IRQ_PINS(IRQ_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr), .wdata(bus_wdata),
        .dir_q(dir_q), .out_q(out_q), .ictl_q(ictl_q)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_pin
        logic db_en;
        if (i < IRQ_PINS) begin : g_irq_pin
            assign db_en = ictl_q[2*IRQ_PINS + i];
        end else begin : g_plain_pin
            assign db_en = 1'b0;
        end
        gpio_in_filter #(.SYNC_STAGES(SYNC_STAGES), .DB_CYCLES(DB_CYCLES)) u_filt (
            .clk(clk), .rst_n(rst_n), .pin_i(pin_in[i]), .db_en_i(db_en),
            .sync_o(sync_v[i]), .filt_o(filt_v[i])
        );
    end

    gpio_irq_detect #(.IRQ_PINS(IRQ_PINS)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .lvl_i(filt_v[IRQ_PINS-1:0]),
        .rise_en(ictl_q[IRQ_PINS-1:0]),
        .fall_en(ictl_q[2*IRQ_PINS-1:IRQ_PINS]),
        .lvl_mode(ictl_q[4*IRQ_PINS-1:3*IRQ_PINS]),
        .clr_i(clr_v),
        .pend_q(pend_q)
    );

    // Pad-side outputs and combined interrupt.
    assign pin_oe  = ~dir_q;
    assign pin_out = out_q;
    assign irq_out = |pend_q;

    // Combinational read mux; unmapped and write-only offsets read zero.
    always_comb begin
        case (bus_addr)
            OFS_DIR:                    bus_rdata = dir_q;
            OFS_PINS:                   bus_rdata = sync_v;
            OFS_OUT_SET:                bus_rdata = out_q;
            OFS_ICTL_SET, OFS_ICTL_CLR: bus_rdata = DATA_W'(ictl_q);
            OFS_PEND:                   bus_rdata = DATA_W'(pend_q);
            default:                    bus_rdata = '0;
        endcase
    end

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_PEND) |-> (bus_rdata[DATA_W-1:IRQ_PINS] == '0)); // R8
    AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_PEND) |-> (irq_out == (bus_rdata != '0))); // R10

endmodule

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = 32'h0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_bank_irq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Direction model: 1 = input.
    function automatic logic [31:0] next_dir(input logic [31:0] cur, input logic [7:0] a,
                                             input logic [31:0] d);
        if (a == 8'h04) return cur & ~d;
        if (a == 8'h08) return cur | d;
        return cur;
    endfunction

    // Output latch model.
    function automatic logic [31:0] next_out(input logic [31:0] cur, input logic [7:0] a,
                                             input logic [31:0] d);
        if (a == 8'h10) return cur | d;
        if (a == 8'h14) return cur & ~d;
        return cur;
    endfunction

    initial begin
        logic [31:0] d, dir_m, out_m, c1, c2, v;
        logic [7:0] ops [7];
        ops[0] = 8'h04; ops[1] = 8'h08; ops[2] = 8'h10; ops[3] = 8'h14;
        ops[4] = 8'h00; ops[5] = 8'h0C; ops[6] = 8'h24;
        void'($urandom(32'd4242));
        waitc(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, d); chk("R1 dir", d, 32'hFFFF_FFFF);
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 out", pin_out, 32'h0);
        rd(8'h18, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h24, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'h0, irq_out}, 32'h0);

        // R2 R3 R12: random alias writes against bench models
        dir_m = 32'hFFFF_FFFF; out_m = 32'h0;
        for (int k = 0; k < 120; k++) begin
            logic [7:0] a;
            a = ops[$urandom_range(0, 6)];
            v = $urandom;
            wr(a, v);
            dir_m = next_dir(dir_m, a, v);
            out_m = next_out(out_m, a, v);
            rd(8'h00, d); chk("R2 dir read", d, dir_m);
            chk("R2 oe", pin_oe, ~dir_m);
            rd(8'h10, d); chk("R3 out read", d, out_m);
            chk("R3 pin_out", pin_out, out_m);
        end
        rd(8'h24, d); chk("R12 status untouched", d, 32'h0);

        // R4 synchronised pin readback
        for (int k = 0; k < 4; k++) begin
            v = $urandom;
            pin_in = v;
            waitc(3);
            rd(8'h0C, d); chk("R4 pin read", d, v);
        end

        // R5 control word aliases
        c1 = $urandom; c2 = $urandom;
        wr(8'h18, c1); rd(8'h18, d); chk("R5 ctrl set", d, c1);
        wr(8'h1C, c2); rd(8'h1C, d); chk("R5 ctrl clr", d, c1 & ~c2);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h18, d); chk("R5 ctrl zero", d, 32'h0);
        pin_in = 32'h0; waitc(8);
        wr(8'h20, 32'hFF); rd(8'h24, d); chk("R9 clean", d, 32'h0);

        // R6 edge modes
        wr(8'h18, 32'h0000_0001);              // pin0 rise
        pin_in[0] = 1'b1; waitc(6);
        rd(8'h24, d); chk("R6 rise", d, 32'h01);
        chk("R10 irq high", {31'h0, irq_out}, 32'h1);
        wr(8'h20, 32'h01); rd(8'h24, d); chk("R9 clear", d, 32'h0);
        chk("R10 irq low", {31'h0, irq_out}, 32'h0);
        pin_in[0] = 1'b0; waitc(6);
        rd(8'h24, d); chk("R6 rise ignores fall", d, 32'h0);
        wr(8'h18, 32'h0000_0200);              // pin1 fall
        pin_in[1] = 1'b1; waitc(6);
        rd(8'h24, d); chk("R6 fall ignores rise", d, 32'h0);
        pin_in[1] = 1'b0; waitc(6);
        rd(8'h24, d); chk("R6 fall", d, 32'h02);
        wr(8'h18, 32'h0000_0404);              // pin2 both
        pin_in[2] = 1'b1; waitc(6);
        rd(8'h24, d); chk("R6 both rise", d, 32'h06);
        wr(8'h20, 32'h04);                     // R9: pin1 bit stays
        rd(8'h24, d); chk("R9 zero bits keep", d, 32'h02);
        pin_in[2] = 1'b0; waitc(6);
        rd(8'h24, d); chk("R6 both fall", d, 32'h06);
        wr(8'h20, 32'hFF);

        // R8 masking and upper pins
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h18, 32'h1000_0000);              // pin4 level, no polarity
        pin_in[4] = 1'b1; pin_in[3] = 1'b1; waitc(6);
        rd(8'h24, d); chk("R8 masked", d, 32'h0);
        pin_in[4] = 1'b0; pin_in[3] = 1'b0;
        wr(8'h1C, 32'hFFFF_FFFF);
        waitc(6);
        wr(8'h18, 32'h0000_FFFF);
        pin_in[12] = 1'b1; pin_in[31] = 1'b1; waitc(6);
        pin_in[12] = 1'b0; pin_in[31] = 1'b0; waitc(6);
        rd(8'h24, d); chk("R8 upper pins", d, 32'h0);
        chk("R8 irq", {31'h0, irq_out}, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF);

        // R7 level modes and clear-versus-set collision
        wr(8'h18, 32'h2000_0020);              // pin5 level high
        pin_in[5] = 1'b1; waitc(6);
        rd(8'h24, d); chk("R7 level high", d, 32'h20);
        wr(8'h20, 32'h20);
        rd(8'h24, d); chk("R7 set wins over clear", d, 32'h20);
        pin_in[5] = 1'b0; waitc(6);
        wr(8'h20, 32'h20);
        rd(8'h24, d); chk("R7 clear after release", d, 32'h0);
        wr(8'h18, 32'h4000_4000);              // pin6 level low
        waitc(3);
        rd(8'h24, d); chk("R7 level low", d, 32'h40);
        pin_in[6] = 1'b1; waitc(6);
        wr(8'h20, 32'h40);
        rd(8'h24, d); chk("R7 low released", d, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF);
        pin_in[6] = 1'b0; waitc(6);
        wr(8'h20, 32'hFF);

        // R11 debounce on pin7
        wr(8'h18, 32'h0080_0080);
        pin_in[7] = 1'b1; waitc(5); pin_in[7] = 1'b0; waitc(30);
        rd(8'h24, d); chk("R11 glitch ignored", d, 32'h0);
        pin_in[7] = 1'b1; waitc(10);
        rd(8'h24, d); chk("R11 still filtering", d, 32'h0);
        waitc(30);
        rd(8'h24, d); chk("R11 accepted", d, 32'h80);
        chk("R10 irq debounced", {31'h0, irq_out}, 32'h1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule